// File: doc/BRIEF.md
# One-Shot Two-Phase PWM Timer

This block is a 16-bit down counter that makes one two-phase pulse each time it is started, and then stops. Two reload values set the lengths of the two phases. The count clock reaches the block as a one-clock enable strobe, so the counter moves only on clocks where that strobe is high. Every underflow toggles an output flip-flop. A start trigger for other timers pulses at each underflow. Interrupt and DMA request pulses mark the end of the second phase.

Software writes the two reload values and an enable bit, and it may also write an initial level for the flip-flop. A run starts when software writes the enable bit to one or when the external start input pulses while the block is idle. If either reload holds all ones, that phase's underflow does not toggle the flip-flop. This gives 0% or 100% duty. In such a run, the flip-flop changes and the requests are delayed by one count tick, but the start trigger is not.

Top module: `oneshot_pwm_timer`

## Requirements
- R1: The counter changes only on clocks where cnt_tick_i is high. The first tick after a start loads reload0 minus one. Phase 0 therefore lasts reload0+1 ticks, counting the load tick and ending at the tick that produces the underflow.
- R2: The tick after the first underflow loads reload1 minus one. Phase 1 lasts reload1+1 ticks. busy_o falls in the clock after the second underflow, and counting stops there.
- R3: An underflow leaves cnt_o at 16'hFFFF, including a load of a zero reload. cnt_o keeps that value until the next tick loads the next phase.
- R4: ff_o inverts at every underflow whose reload is not all ones. Starting a run never inverts it.
- R5: irq_o and dma_o pulse together once per run, at the second underflow.
- R6: A reload of 16'hFFFF suppresses that phase's toggle. When either captured reload is all ones, every toggle and the request pulses of that run come one tick later than the underflow that caused them.
- R7: trig_o pulses at both underflows of a run and is never delayed.
- R8: Writing the enable bit to zero stops the run in that same clock. The counter holds its value, and any delayed toggle or request still waiting is dropped.
- R9: When a disable write and a start (external or software) land in the same clock, the disable wins and the block stays idle.
- R10: A start captures the reload pair. Writes made during a run do not change that run. A written reload1 value joins the pair used by the next start only once reload0 is written afterwards.
- R11: A start is either a write of enable one or a one-clock pulse on ext_start_i while idle. A start request while busy is ignored.
- R12: irq_o, dma_o and trig_o are one-clock pulses. Each pulse is registered off a tick edge.
- R13: A write to the initial-level control sets ff_o. ff_o otherwise keeps its level across runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_tick_i | input | 1 | Count-clock enable strobe |
| rld0_we_i | input | 1 | Write strobe for reload0 (also commits staged reload1) |
| rld1_we_i | input | 1 | Write strobe for staged reload1 |
| wdata_i | input | 16 | Reload write data |
| en_we_i | input | 1 | Write strobe for the enable bit |
| en_val_i | input | 1 | Enable bit value: 1 starts, 0 stops |
| ext_start_i | input | 1 | External start pulse |
| init_we_i | input | 1 | Write strobe for the flip-flop level |
| init_lvl_i | input | 1 | Level loaded into the flip-flop |
| cnt_o | output | 16 | Current counter value |
| busy_o | output | 1 | Run in progress |
| ff_o | output | 1 | PWM flip-flop output |
| irq_o | output | 1 | Interrupt request pulse |
| dma_o | output | 1 | DMA request pulse |
| trig_o | output | 1 | Start trigger to other timers |

## Verification
On every cycle, the assertions check that the counter and the flip-flop hold still between ticks. They also check that each underflow leaves the counter at all ones, that busy falls after the second underflow and after a disable, that requests are single pulses, and that staged reload1 commits only on a reload0 write. Only the bench scenarios can show the whole pulse timeline: the phase lengths, the one-tick shift of toggles and requests in an all-ones run while the trigger stays put, and the race between disable and start. The same holds for the deferred pickup of new reloads across successive runs and for flip-flop level retention.

// File: rtl/oneshot_pwm_pkg.sv
package oneshot_pwm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,   // started, waiting for first tick to load phase 0
    ST_RUN0,
    ST_GAP,   // underflow 0 seen, next tick loads phase 1
    ST_RUN1
  } phase_e;
endpackage

// File: rtl/reload_bank.sv
module reload_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rld0_we_i,
  input  logic         rld1_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rld0_o,
  output logic [W-1:0] rld1_o
);
  logic [W-1:0] r0_q, r1_stage_q, r1_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0_q       <= '0;
      r1_stage_q <= '0;
      r1_pend_q  <= '0;
    end else begin
      if (rld1_we_i) r1_stage_q <= wdata_i;
      if (rld0_we_i) begin
        r0_q      <= wdata_i;
        r1_pend_q <= rld1_we_i ? wdata_i : r1_stage_q;
      end
    end
  end

  assign rld0_o = r0_q;
  assign rld1_o = r1_pend_q;

  // R10
  r1_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rld0_we_i |=> $stable(rld1_o));
endmodule

// File: rtl/phase_counter.sv
module phase_counter
  import oneshot_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic [W-1:0] rld0_i,
  input  logic [W-1:0] rld1_i,
  output logic [W-1:0] cnt_o,
  output logic         busy_o,
  output logic         uf0_o,
  output logic         uf1_o,
  output logic [W-1:0] act0_o,
  output logic [W-1:0] act1_o
);
  localparam logic [W-1:0] ONE = W'(1);

  phase_e       state_q;
  logic [W-1:0] cnt_q, act0_q, act1_q;
  logic         cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    uf0_o = 1'b0;
    uf1_o = 1'b0;
    if (tick_i && !stop_i) begin
      uf0_o = (state_q == ST_ARM  && act0_q == '0) || (state_q == ST_RUN0 && cnt_zero);
      uf1_o = (state_q == ST_GAP  && act1_q == '0) || (state_q == ST_RUN1 && cnt_zero);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      act0_q  <= '0;
      act1_q  <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else if (start_i && state_q == ST_IDLE) begin
      state_q <= ST_ARM;
      act0_q  <= rld0_i;
      act1_q  <= rld1_i;
    end else if (tick_i) begin
      unique case (state_q)
        ST_ARM: begin
          cnt_q   <= act0_q - ONE;
          state_q <= (act0_q == '0) ? ST_GAP : ST_RUN0;
        end
        ST_RUN0: begin
          cnt_q <= cnt_q - ONE;
          if (cnt_zero) state_q <= ST_GAP;
        end
        ST_GAP: begin
          cnt_q   <= act1_q - ONE;
          state_q <= (act1_q == '0) ? ST_IDLE : ST_RUN1;
        end
        ST_RUN1: begin
          cnt_q <= cnt_q - ONE;
          if (cnt_zero) state_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (state_q != ST_IDLE);
  assign act0_o = act0_q;
  assign act1_o = act1_q;

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R3
  uf_ffff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf0_o || uf1_o) |=> (cnt_q == '1));
  // R2
  uf1_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf1_o |=> !busy_o);
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         stop_i,
  input  logic         uf0_i,
  input  logic         uf1_i,
  input  logic [W-1:0] act0_i,
  input  logic [W-1:0] act1_i,
  input  logic         init_we_i,
  input  logic         init_lvl_i,
  output logic         ff_o,
  output logic         irq_o,
  output logic         dma_o,
  output logic         trig_o
);
  logic ff_q, irq_q, dma_q, trig_q;
  logic tog_pend_q, req_pend_q;
  logic flat, tog_now, tog_eff, req_eff;

  assign flat    = (act0_i == '1) || (act1_i == '1);
  assign tog_now = (uf0_i && act0_i != '1) || (uf1_i && act1_i != '1);
  assign tog_eff = tog_pend_q ^ (!flat && tog_now);
  assign req_eff = req_pend_q || (!flat && uf1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q       <= 1'b0;
      irq_q      <= 1'b0;
      dma_q      <= 1'b0;
      trig_q     <= 1'b0;
      tog_pend_q <= 1'b0;
      req_pend_q <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= 1'b0;
      if (stop_i) begin
        tog_pend_q <= 1'b0;
        req_pend_q <= 1'b0;
      end else if (tick_i) begin
        trig_q     <= uf0_i || uf1_i;
        irq_q      <= req_eff;
        dma_q      <= req_eff;
        tog_pend_q <= flat && tog_now;
        req_pend_q <= flat && uf1_i;
      end
      if (init_we_i)                       ff_q <= init_lvl_i;
      else if (!stop_i && tick_i && tog_eff) ff_q <= ~ff_q;
    end
  end

  assign ff_o   = ff_q;
  assign irq_o  = irq_q;
  assign dma_o  = dma_q;
  assign trig_o = trig_q;

  // R13
  ff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !init_we_i) |=> $stable(ff_q));
  // R12
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R12
  trig_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !trig_q);
endmodule

// File: rtl/oneshot_pwm_timer.sv
module oneshot_pwm_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_tick_i,
  input  logic         rld0_we_i,
  input  logic         rld1_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         en_we_i,
  input  logic         en_val_i,
  input  logic         ext_start_i,
  input  logic         init_we_i,
  input  logic         init_lvl_i,
  output logic [W-1:0] cnt_o,
  output logic         busy_o,
  output logic         ff_o,
  output logic         irq_o,
  output logic         dma_o,
  output logic         trig_o
);
  logic         start_req, stop_req, uf0, uf1;
  logic [W-1:0] rld0, rld1, act0, act1;

  assign start_req = (en_we_i && en_val_i) || ext_start_i;
  assign stop_req  = en_we_i && !en_val_i;

  reload_bank #(.W(W)) u_bank (
    .clk_i, .rst_ni,
    .rld0_we_i, .rld1_we_i, .wdata_i,
    .rld0_o(rld0), .rld1_o(rld1)
  );

  phase_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i(cnt_tick_i), .start_i(start_req), .stop_i(stop_req),
    .rld0_i(rld0), .rld1_i(rld1),
    .cnt_o, .busy_o,
    .uf0_o(uf0), .uf1_o(uf1), .act0_o(act0), .act1_o(act1)
  );

  pwm_out_stage #(.W(W)) u_out (
    .clk_i, .rst_ni,
    .tick_i(cnt_tick_i), .stop_i(stop_req),
    .uf0_i(uf0), .uf1_i(uf1), .act0_i(act0), .act1_i(act1),
    .init_we_i, .init_lvl_i,
    .ff_o, .irq_o, .dma_o, .trig_o
  );

  // R8 R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req |=> !busy_o);
endmodule

// File: tb/tb_oneshot_pwm_timer.sv
module tb_oneshot_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, rld0_we = 1'b0, rld1_we = 1'b0;
  logic [15:0] wdata = '0;
  logic        en_we = 1'b0, en_val = 1'b0, ext_start = 1'b0;
  logic        init_we = 1'b0, init_lvl = 1'b0;
  logic [15:0] cnt;
  logic        busy, ff, irq, dma, trig;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #10 clk = ~clk;

  oneshot_pwm_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_tick_i(tick),
    .rld0_we_i(rld0_we), .rld1_we_i(rld1_we), .wdata_i(wdata),
    .en_we_i(en_we), .en_val_i(en_val), .ext_start_i(ext_start),
    .init_we_i(init_we), .init_lvl_i(init_lvl),
    .cnt_o(cnt), .busy_o(busy), .ff_o(ff), .irq_o(irq), .dma_o(dma), .trig_o(trig)
  );

  // {reload0, reload1}
  localparam logic [31:0] VEC [5] = '{
    {16'd3, 16'd2}, {16'd0, 16'd4}, {16'd5, 16'd0}, {16'd1, 16'd1}, {16'd3, 16'hFFFF}
  };

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic wr_r0(input logic [15:0] v);
    @(negedge clk) rld0_we = 1'b1; wdata = v;
    @(negedge clk) rld0_we = 1'b0;
  endtask
  task automatic wr_r1(input logic [15:0] v);
    @(negedge clk) rld1_we = 1'b1; wdata = v;
    @(negedge clk) rld1_we = 1'b0;
  endtask
  task automatic sw_start();
    @(negedge clk) en_we = 1'b1; en_val = 1'b1;
    @(negedge clk) en_we = 1'b0; en_val = 1'b0;
  endtask
  task automatic sw_stop();
    @(negedge clk) en_we = 1'b1; en_val = 1'b0;
    @(negedge clk) en_we = 1'b0;
  endtask
  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // tick every clock; returns clock index (1 = first clock after start edge) of irq
  task automatic run_irq(input bit mid_wr, output int t);
    t = -1;
    tick = 1'b1;
    sw_start();
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      if (irq && t < 0) t = n;
      rld0_we = 1'b0; rld1_we = 1'b0;
      if (mid_wr && n == 2) begin rld1_we = 1'b1; wdata = 16'd1; end
      if (mid_wr && n == 3) begin rld0_we = 1'b1; wdata = 16'd1; end
    end
    tick = 1'b0;
  endtask

  task automatic run_case(input logic [15:0] r0, input logic [15:0] r1);
    int u0, u1, d, ntrig, t0, t1, nirq, tirq, ndma, ntog, tg0, tg1, entog, e0, e1;
    bit fl, b_pre, b_at;
    logic ffp;
    fl = (r0 == 16'hFFFF) || (r1 == 16'hFFFF);
    d  = fl ? 1 : 0;
    u0 = int'(r0) + 1;
    u1 = int'(r0) + int'(r1) + 2;
    ntrig = 0; t0 = -1; t1 = -1; nirq = 0; tirq = -1; ndma = 0; ntog = 0; tg0 = -1; tg1 = -1;
    tick = 1'b1;
    wr_r1(r1);
    wr_r0(r0);
    sw_start();
    ffp = ff;
    for (int n = 1; n <= u1 + 4; n++) begin
      @(negedge clk);
      if (trig) begin if (ntrig == 0) t0 = n; else t1 = n; ntrig++; end
      if (irq) begin tirq = n; nirq++; end
      if (dma) ndma++;
      if (ff !== ffp) begin if (ntog == 0) tg0 = n; else tg1 = n; ntog++; ffp = ff; end
      if (n == u1 - 1) b_pre = busy;
      if (n == u1) b_at = busy;
    end
    tick = 1'b0;
    entog = 0; e0 = -1; e1 = -1;
    if (r0 != 16'hFFFF) begin e0 = u0 + d; entog++; end
    if (r1 != 16'hFFFF) begin if (entog == 0) e0 = u1 + d; else e1 = u1 + d; entog++; end
    chk("R7 first trigger time", ntrig == 2 && t0 == u0, t0, u0);
    chk("R7 second trigger time", t1 == u1, t1, u1);
    chk("R1 R2 busy before end", b_pre == 1'b1, b_pre, 1);
    chk("R2 busy after second underflow", b_at == 1'b0, b_at, 0);
    chk("R5 R6 irq time", nirq == 1 && tirq == u1 + d, tirq, u1 + d);
    chk("R5 dma count", ndma == 1, ndma, 1);
    chk("R4 R6 toggle count", ntog == entog, ntog, entog);
    chk("R4 R6 first toggle time", tg0 == e0, tg0, e0);
    chk("R4 R6 second toggle time", tg1 == e1, tg1, e1);
  endtask

  initial begin
    int t, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset cnt", cnt == 16'd0, cnt, 0);
    chk("R13 reset ff", ff == 1'b0, ff, 0);
    chk("R12 reset pulses", {busy, irq, dma, trig} == 4'b0, {busy, irq, dma, trig}, 0);

    // sparse ticks, reload0=2 reload1=1
    wr_r1(16'd1);
    wr_r0(16'd2);
    sw_start();
    chk("R4 no toggle at start", ff == 1'b0, ff, 0);
    tick_once();
    chk("R1 load reload0-1", cnt == 16'd1, cnt, 1);
    chk("R11 busy after sw start", busy == 1'b1, busy, 1);
    @(negedge clk);
    chk("R1 hold between ticks", cnt == 16'd1, cnt, 1);
    tick_once();
    chk("R1 decrement", cnt == 16'd0, cnt, 0);
    tick_once();
    chk("R3 underflow value", cnt == 16'hFFFF, cnt, 16'hFFFF);
    chk("R7 trigger at underflow 0", trig == 1'b1, trig, 1);
    chk("R4 toggle at underflow 0", ff == 1'b1, ff, 1);
    @(negedge clk);
    chk("R12 trigger single clock", trig == 1'b0, trig, 0);
    chk("R3 value held until tick", cnt == 16'hFFFF, cnt, 16'hFFFF);
    tick_once();
    chk("R2 load reload1-1", cnt == 16'd0, cnt, 0);
    chk("R5 no irq after first underflow", irq == 1'b0, irq, 0);
    tick_once();
    chk("R5 irq at underflow 1", irq == 1'b1 && dma == 1'b1, {irq, dma}, 3);
    chk("R2 stopped", busy == 1'b0, busy, 0);
    chk("R4 toggle at underflow 1", ff == 1'b0, ff, 0);
    @(negedge clk);
    chk("R12 irq single clock", irq == 1'b0, irq, 0);

    // initial level and retention
    @(negedge clk) init_we = 1'b1; init_lvl = 1'b1;
    @(negedge clk) init_we = 1'b0; init_lvl = 1'b0;
    chk("R13 init level written", ff == 1'b1, ff, 1);
    wr_r1(16'd2);
    wr_r0(16'd1);
    tick = 1'b1;
    sw_start();
    seen = 0;
    for (int n = 0; n < 10; n++) begin @(negedge clk); if (n == 0 && ff != 1'b1) seen = 99; end
    tick = 1'b0;
    chk("R13 level kept across run", ff == 1'b1 && seen == 0, ff, 1);

    // disable mid-run
    wr_r1(16'd10);
    wr_r0(16'd10);
    sw_start();
    tick_once(); tick_once(); tick_once();
    chk("R1 three ticks", cnt == 16'd7, cnt, 7);
    @(negedge clk) en_we = 1'b1; en_val = 1'b0; tick = 1'b1;
    @(negedge clk) en_we = 1'b0; tick = 1'b0;
    chk("R8 counter frozen on disable", cnt == 16'd7, cnt, 7);
    chk("R8 idle after disable", busy == 1'b0, busy, 0);
    seen = 0;
    for (int n = 0; n < 20; n++) begin tick_once(); if (trig || irq) seen++; end
    chk("R8 no events after disable", seen == 0 && cnt == 16'd7, seen, 0);

    // disable and external start in the same clock
    @(negedge clk) en_we = 1'b1; en_val = 1'b0; ext_start = 1'b1;
    @(negedge clk) en_we = 1'b0; ext_start = 1'b0;
    chk("R9 disable wins", busy == 1'b0, busy, 0);
    tick_once();
    chk("R9 counter untouched", cnt == 16'd7, cnt, 7);

    // external start, then start while busy
    @(negedge clk) ext_start = 1'b1;
    @(negedge clk) ext_start = 1'b0;
    chk("R11 busy after ext start", busy == 1'b1, busy, 1);
    tick_once();
    chk("R11 ext start loads", cnt == 16'd9, cnt, 9);
    sw_start();
    tick_once();
    chk("R11 start while busy ignored", cnt == 16'd8, cnt, 8);
    sw_stop();

    // reload writes during and between runs
    wr_r1(16'd5);
    wr_r0(16'd5);
    run_irq(1'b1, t);
    chk("R10 run unaffected by writes", t == 12, t, 12);
    run_irq(1'b0, t);
    chk("R10 new pair next run", t == 4, t, 4);
    wr_r1(16'd2);
    run_irq(1'b0, t);
    chk("R10 reload1 staged", t == 4, t, 4);
    wr_r0(16'd1);
    run_irq(1'b0, t);
    chk("R10 reload1 committed by reload0", t == 5, t, 5);

    // table of reload pairs, tick every clock
    for (int i = 0; i < 5; i++) run_case(VEC[i][31:16], VEC[i][15:0]);

    finish_run();
  end
endmodule